// File: doc/BRIEF.md
# Half-Flash ADC Bus Sequencer

This block is the converter-side control logic of an 8-bit half-flash analog-to-digital converter with a parallel bus. The analog comparators are absent. A digital `sample` input stands in for the held analog value, and a parameterised clock count stands in for the settling time of each conversion half. The block decodes chip select, read, write and power-down, all active low except power-down. It sequences the conversion as an upper-nibble phase followed by a lower-nibble phase. It latches each half into the output buffer at the protocol event that belongs to it, and it drives the status outputs and the byte bus. All bus inputs are taken to be synchronous to `clk`. An edge counts at the first clock edge whose sampled level differs from the one before.

`mode` selects between two protocols. With `mode` low (read-only), a falling read strobe while select is low starts a conversion. The host keeps read low and the byte appears once the conversion completes. The ready line is pulled low from the select falling edge until the conversion ends. With `mode` high (write-then-read), a falling write strobe starts a conversion. The upper nibble is latched when write returns high, provided the upper phase has finished by then. The lower phase follows, the interrupt line falls, and a read then puts the byte on the bus.

The states are: `ST_IDLE` (waiting), `ST_R_HI` and `ST_R_LO` (read-only halves), `ST_W_HI` (write-mode upper half), `ST_W_WAIT` (upper half done, write still low), `ST_W_LO` (write-mode lower half) and `ST_DONE` (result ready, interrupt low). The transitions are:
- start: IDLE/DONE to R_HI or W_HI.
- upper done: R_HI to R_LO.
- W_HI to W_LO, when write has already risen.
- W_HI to W_WAIT, otherwise.
- write rise: W_WAIT to W_LO.
- lower done: R_LO/W_LO to DONE.
- release: DONE to IDLE, on a rise of select or read.
- power-down: any state to IDLE.

Top module: `hfadc_seq`

## Requirements
- R1: After reset, `int_n` is 1, `rdy_oe` is 0 and `data_oe` is 0.
- R2: With `mode`=0, a read fall seen while `cs_n` is 0 starts a conversion. `int_n` falls exactly 2*HALF_CYCLES clock edges after the edge that sees the read fall. At that same edge, `data_oe` goes to 1 with the converted byte on `data_out` while `cs_n` and `rd_n` stay 0.
- R3: With `mode`=0, `rdy_oe` (1 = pulling the ready line low) becomes 1 at the edge that sees `cs_n` fall. It returns to 0 at the edge where `int_n` falls.
- R4: While `int_n` is 0, a rise of `cs_n` or of `rd_n` returns `int_n` to 1 at the edge that sees the rise.
- R5: With `mode`=1, a write fall seen while `cs_n` is 0 starts a conversion. If `wr_n` is still 0 when the upper phase ends, `int_n` falls HALF_CYCLES edges after the edge that sees `wr_n` rise.
- R6: With `mode`=1, if `wr_n` rises before the upper phase ends, the upper nibble is latched when that phase ends. `int_n` then falls 2*HALF_CYCLES edges after the start edge.
- R7: `data_oe` is 0 whenever `cs_n` or `rd_n` is 1, and also before `int_n` has fallen for the current conversion, even when read is already low.
- R8: While `pwrdn` is 1, conversion starts are ignored, `int_n` is held at 1 and `data_oe` at 0. Asserting `pwrdn` mid-conversion abandons that conversion, and no interrupt follows once `pwrdn` is released.
- R9: The converted byte is `sample` as seen at the start edge. Bits 7:4 form the upper nibble and bits 3:0 the lower nibble. Later changes of `sample` do not alter it.
- R10: With `mode`=1, `rdy_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 = read-only protocol, 1 = write-then-read protocol |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (used only when `mode`=1) |
| pwrdn | input | 1 | Power-down, active high |
| sample | input | DATA_W | Digital stand-in for the held analog input |
| data_out | output | DATA_W | Byte presented to the bus |
| data_oe | output | 1 | Bus driver enable; 0 means high impedance |
| int_n | output | 1 | End-of-conversion interrupt, active low |
| rdy_oe | output | 1 | Open-drain ready pull-down enable (1 = line pulled low) |

## Verification
Every result is due at a fixed edge counted from the edge that first sees the stimulus. `rdy_oe` is due at that same edge. `int_n` falls 2*HALF_CYCLES edges after a read-mode or early-write start, and HALF_CYCLES edges after a late write rise. `int_n` releases one edge after a select or read rise. `data_oe` follows the strobes combinationally once the result is ready. The bench drives on falling clock edges and samples 2 ns after a chosen rising edge. It checks each timed output both one edge before its due edge and at that edge, so both an early change and a late change are caught.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_R_HI,
        ST_R_LO,
        ST_W_HI,
        ST_W_WAIT,
        ST_W_LO,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
    } bus_ev_t;

    localparam int unsigned BUS_EV_W = $bits(bus_ev_t);

endpackage

// File: rtl/hfadc_edge_det.sv
module hfadc_edge_det #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall,
    output logic [W-1:0] rise
);

    logic [W-1:0] lvl_q;

    // Bus strobes idle high, so the previous level resets high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '1;
        end else begin
            lvl_q <= lvl;
        end
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            assign fall[g] =  lvl_q[g] & ~lvl[g];
            assign rise[g] = ~lvl_q[g] &  lvl[g];
        end
    endgenerate

endmodule

// File: rtl/hfadc_phase_cnt.sv
module hfadc_phase_cnt #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hfadc_result_buf.sv
module hfadc_result_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] sample,
    input  logic              latch_hi,
    input  logic              latch_lo,
    output logic [DATA_W-1:0] result
);

    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] hold_q;
    logic [1:0]        half_en;

    assign half_en = {latch_hi, latch_lo};

    // Track-and-hold stand-in: the whole input is frozen at the start edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= sample;
        end
    end

    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result[h*HALF_W +: HALF_W] <= '0;
                end else if (half_en[h]) begin
                    result[h*HALF_W +: HALF_W] <= hold_q[h*HALF_W +: HALF_W];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hfadc_fsm.sv
module hfadc_fsm
    import hfadc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mode,
    input  logic    pwrdn,
    input  logic    cs_n,
    input  bus_ev_t ev_fall,
    input  bus_ev_t ev_rise,
    input  logic    phase_done,
    output logic    phase_run,
    output logic    phase_clear,
    output logic    capture,
    output logic    latch_hi,
    output logic    latch_lo,
    output logic    result_ready,
    output logic    int_n,
    output logic    rdy_oe
);

    seq_state_t state, state_next;
    logic       wr_early;
    logic       start_rd, start_wr;
    logic       release_ev;

    assign start_rd   = !mode && ev_fall.rd && !cs_n && !pwrdn;
    assign start_wr   =  mode && ev_fall.wr && !cs_n && !pwrdn;
    assign release_ev = ev_rise.cs || ev_rise.rd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_next;
        end
    end

    // Next state and latch strobes
    always_comb begin
        state_next = state;
        capture    = 1'b0;
        latch_hi   = 1'b0;
        latch_lo   = 1'b0;
        if (pwrdn) begin
            state_next = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start_rd) begin
                        state_next = ST_R_HI;
                        capture    = 1'b1;
                    end else if (start_wr) begin
                        state_next = ST_W_HI;
                        capture    = 1'b1;
                    end else if (state == ST_DONE && release_ev) begin
                        state_next = ST_IDLE;
                    end
                end
                ST_R_HI: begin
                    if (phase_done) begin
                        latch_hi   = 1'b1;
                        state_next = ST_R_LO;
                    end
                end
                ST_R_LO: begin
                    if (phase_done) begin
                        latch_lo   = 1'b1;
                        state_next = ST_DONE;
                    end
                end
                ST_W_HI: begin
                    if (phase_done) begin
                        if (wr_early || ev_rise.wr) begin
                            latch_hi   = 1'b1;
                            state_next = ST_W_LO;
                        end else begin
                            state_next = ST_W_WAIT;
                        end
                    end
                end
                ST_W_WAIT: begin
                    if (ev_rise.wr) begin
                        latch_hi   = 1'b1;
                        state_next = ST_W_LO;
                    end
                end
                ST_W_LO: begin
                    if (phase_done) begin
                        latch_lo   = 1'b1;
                        state_next = ST_DONE;
                    end
                end
                default: state_next = ST_IDLE;
            endcase
        end
    end

    assign phase_run   = (state == ST_R_HI) || (state == ST_R_LO) ||
                         (state == ST_W_HI) || (state == ST_W_LO);
    assign phase_clear = (state_next != state);
    assign result_ready = (state == ST_DONE);

    // Remembers a write release that arrives during the upper phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_early <= 1'b0;
        end else if (capture) begin
            wr_early <= 1'b0;
        end else if (state == ST_W_HI && ev_rise.wr) begin
            wr_early <= 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_n  <= 1'b1;
            rdy_oe <= 1'b0;
        end else begin
            int_n <= (state_next != ST_DONE);
            if (pwrdn || mode || ev_rise.cs) begin
                rdy_oe <= 1'b0;
            end else if (state == ST_R_LO && phase_done) begin
                rdy_oe <= 1'b0;
            end else if (ev_fall.cs) begin
                rdy_oe <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hfadc_seq.sv
module hfadc_seq
    import hfadc_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned HALF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              pwrdn,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              int_n,
    output logic              rdy_oe
);

    bus_ev_t              bus_lvl, ev_fall, ev_rise;
    logic [BUS_EV_W-1:0]  fall_v, rise_v;
    logic                 phase_run, phase_clear, phase_done;
    logic                 capture, latch_hi, latch_lo, result_ready;

    assign bus_lvl = '{cs: cs_n, rd: rd_n, wr: wr_n};
    assign ev_fall = bus_ev_t'(fall_v);
    assign ev_rise = bus_ev_t'(rise_v);

    hfadc_edge_det #(.W(BUS_EV_W)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (bus_lvl),
        .fall  (fall_v),
        .rise  (rise_v)
    );

    hfadc_phase_cnt #(.CYCLES(HALF_CYCLES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_clear),
        .run   (phase_run),
        .done  (phase_done)
    );

    hfadc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .pwrdn        (pwrdn),
        .cs_n         (cs_n),
        .ev_fall      (ev_fall),
        .ev_rise      (ev_rise),
        .phase_done   (phase_done),
        .phase_run    (phase_run),
        .phase_clear  (phase_clear),
        .capture      (capture),
        .latch_hi     (latch_hi),
        .latch_lo     (latch_lo),
        .result_ready (result_ready),
        .int_n        (int_n),
        .rdy_oe       (rdy_oe)
    );

    hfadc_result_buf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .sample   (sample),
        .latch_hi (latch_hi),
        .latch_lo (latch_lo),
        .result   (data_out)
    );

    // Bus driver: only with a finished result and both strobes low.
    assign data_oe = result_ready && !cs_n && !rd_n && !pwrdn;

endmodule

// File: rtl/hfadc_seq_chk.sv
module hfadc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mode,
    input logic cs_n,
    input logic rd_n,
    input logic pwrdn,
    input logic data_oe,
    input logic int_n,
    input logic rdy_oe
);

    // R7: the bus is never driven before the interrupt has fallen
    a_r7_bus_after_int: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !int_n);

    // R8: power-down holds the interrupt inactive
    a_r8_pwrdn_int_high: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> int_n);

    // R4: a select or read rise releases a pending interrupt
    a_r4_int_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && ($rose(cs_n) || $rose(rd_n))) |=> int_n);

    // R3: ready asserts on a select fall in read-only mode
    a_r3_rdy_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !pwrdn && $fell(cs_n)) |=> rdy_oe);

    // R3: ready is released together with the interrupt
    a_r3_rdy_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_n) && !mode) |-> !rdy_oe);

    // R10: no ready pull-down in write-then-read mode
    a_r10_no_rdy_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> !rdy_oe);

endmodule

bind hfadc_seq hfadc_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .pwrdn   (pwrdn),
    .data_oe (data_oe),
    .int_n   (int_n),
    .rdy_oe  (rdy_oe)
);

// File: tb/hfadc_seq_tb.sv
`timescale 1ns/1ps
module hfadc_seq_tb;

    localparam int HC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       pwrdn = 1'b0;
    logic [7:0] sample = 8'h00;
    logic [7:0] data_out;
    logic       data_oe, int_n, rdy_oe;

    int nvec = 0;
    int nbad = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    hfadc_seq #(.DATA_W(8), .HALF_CYCLES(HC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .pwrdn(pwrdn), .sample(sample), .data_out(data_out),
        .data_oe(data_oe), .int_n(int_n), .rdy_oe(rdy_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        check("R1 int_n", int_n, 1);
        check("R1 rdy_oe", rdy_oe, 0);
        check("R1 data_oe", data_oe, 0);
    endtask

    // Read-only conversion; released by RD (use_cs=0) or CS (use_cs=1).
    task automatic t_read(input logic [7:0] v, input bit use_cs);
        @(negedge clk); mode = 1'b0; sample = v; cs_n = 1'b0; rd_n = 1'b0;
        edges(1);                                   // start edge k
        check("R3 rdy at select fall", rdy_oe, 1);
        check("R2 int high at start", int_n, 1);
        @(negedge clk); sample = ~v;                // R9: change after start
        edges(2*HC - 1);                            // edge k+7
        check("R2 int before due", int_n, 1);
        check("R7 bus off during conversion", data_oe, 0);
        check("R3 rdy held", rdy_oe, 1);
        edges(1);                                   // edge k+8
        check("R2 int at due edge", int_n, 0);
        check("R3 rdy released", rdy_oe, 0);
        check("R2 bus driven", data_oe, 1);
        check("R9 held byte", data_out, v);
        @(negedge clk);
        if (use_cs) cs_n = 1'b1; else rd_n = 1'b1;
        #1;
        check("R7 bus off on strobe high", data_oe, 0);
        edges(1);
        check("R4 int released", int_n, 1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        edges(2);
    endtask

    // Write-then-read with WR held for hold extra edges after start.
    task automatic t_write_late(input logic [7:0] v, input int hold);
        @(negedge clk); mode = 1'b1; sample = v; cs_n = 1'b0; wr_n = 1'b0;
        edges(1);                                   // start edge k
        check("R10 no rdy in write mode", rdy_oe, 0);
        edges(hold);
        @(negedge clk); wr_n = 1'b1; rd_n = 1'b0; sample = ~v;
        edges(HC);                                  // edge m+HC-1
        check("R5 int before due", int_n, 1);
        check("R7 bus off before int", data_oe, 0);
        edges(1);                                   // edge m+HC
        check("R5 int at due edge", int_n, 0);
        check("R5 bus driven", data_oe, 1);
        check("R9 write byte", data_out, v);
        check("R10 rdy still off", rdy_oe, 0);
        @(negedge clk); rd_n = 1'b1;
        edges(1);
        check("R4 int released by read", int_n, 1);
        @(negedge clk); cs_n = 1'b1;
        edges(2);
    endtask

    // Write-then-read with WR released before the upper phase ends.
    task automatic t_write_early(input logic [7:0] v);
        @(negedge clk); mode = 1'b1; sample = v; cs_n = 1'b0; wr_n = 1'b0;
        edges(1);                                   // start edge k
        @(negedge clk); wr_n = 1'b1; sample = 8'h00;
        edges(2*HC - 1);                            // edge k+7
        check("R6 int before due", int_n, 1);
        edges(1);                                   // edge k+8
        check("R6 int at due edge", int_n, 0);
        check("R7 bus off with read high", data_oe, 0);
        @(negedge clk); rd_n = 1'b0;
        #1;
        check("R6 bus driven after read", data_oe, 1);
        check("R9 nibbles", data_out, v);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        edges(1);
        check("R4 int released by select", int_n, 1);
        edges(2);
    endtask

    task automatic t_pwrdn();
        @(negedge clk); pwrdn = 1'b1; mode = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        edges(3*HC);
        check("R8 start ignored int", int_n, 1);
        check("R8 bus off", data_oe, 0);
        check("R8 no rdy", rdy_oe, 0);
        @(negedge clk); pwrdn = 1'b0;
        edges(3*HC);
        check("R8 no late conversion", int_n, 1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        edges(2);
        // abort mid-conversion
        @(negedge clk); sample = 8'h3C; cs_n = 1'b0; rd_n = 1'b0;
        edges(3);
        @(negedge clk); pwrdn = 1'b1;
        edges(3*HC);
        check("R8 abort int high", int_n, 1);
        check("R8 abort bus off", data_oe, 0);
        @(negedge clk); pwrdn = 1'b0;
        edges(3*HC);
        check("R8 no int after release", int_n, 1);
        check("R8 bus off after release", data_oe, 0);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        edges(2);
    endtask

    initial begin
        edges(3);
        @(negedge clk); rst_n = 1'b1;
        edges(1);
        t_reset();
        t_read(8'hA5, 1'b0);
        t_read(8'h5A, 1'b1);
        t_write_late(8'hC3, 6);
        t_write_late(8'h1E, HC);
        t_write_early(8'h96);
        t_pwrdn();
        t_read(8'hFF, 1'b0);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done_flag) begin
            done_flag = 1'b1;
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule